// File: doc/BRIEF.md
# Effective Address Generator

This block turns an addressing-mode code into the 16-bit effective address an 8-bit processor core needs for its next operand. The caller pulses `start` with the mode code, the program counter (already pointing at the first operand byte) and the two index registers. The block then walks through the operand bytes and any pointer bytes on a simple byte-wide read port. It issues one read per cycle, and each read returns its data on the cycle after it is issued.

When the walk is complete the block raises `done` for one cycle. At that point `ea` holds the target address (or, for the immediate mode, the operand byte itself, with `is_value` set) and `pc_out` holds the program counter advanced past the operand bytes. Modes that carry no operand finish in the cycle they start. An unrecognised code raises `err` in that same cycle and touches memory not at all. Instruction decode and execution are left to the surrounding core.

Top module: `effective_addr_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `done`, `err`, `busy` and `mem_rd` are all 0.
- R2: Mode codes 0 (no operand) and 12 (accumulator) give `done`=1 in the start cycle, with no read, `ea`=0, `pc_out`=`pc_in`, `is_value`=0 and `err`=0.
- R3: Mode codes 13, 14 and 15 give `err`=1 and `done`=1 in the start cycle, with no read at any time, `ea`=0 and `pc_out`=`pc_in`.
- R4: Mode 1 (immediate) reads `pc_in` in the start cycle and gives `done` two cycles later, with `ea`={0x00, byte}, `is_value`=1 and `pc_out`=`pc_in`+1. `is_value` is 0 at `done` for every other mode.
- R5: Modes 2, 3 and 4 (page zero, page zero plus X, page zero plus Y) read `pc_in`, finish two cycles after start, and give `ea`={0x00, (byte + index) mod 256} and `pc_out`=`pc_in`+1.
- R6: Modes 5, 6 and 7 (absolute, plus X, plus Y) read `pc_in` and then `pc_in`+1, low byte first, finish three cycles after start, and give `ea`=(base + index) mod 65536 and `pc_out`=`pc_in`+2.
- R7: Mode 8 (indirect) reads `pc_in`, `pc_in`+1, then the pointer P they form and P+1 (mod 65536). It finishes five cycles after start with `ea`={mem[P+1], mem[P]} and `pc_out`=`pc_in`+2.
- R8: Mode 9 (index before pointer) reads `pc_in`, then Z=(byte+X) mod 256 and (Z+1) mod 256 in page zero. It finishes four cycles after start with `ea` = the pointer read and `pc_out`=`pc_in`+1.
- R9: Mode 10 (index after pointer) reads `pc_in`, then B and (B+1) mod 256 in page zero. It finishes four cycles after start with `ea`=(pointer + Y) mod 65536 and `pc_out`=`pc_in`+1.
- R10: Mode 11 (relative) reads `pc_in`, finishes two cycles after start, and gives `ea`=`pc_in`+1+ the sign-extended byte, mod 65536, and `pc_out`=`pc_in`+1.
- R11: `start` and every input except `mem_rdata` are ignored while `busy` is 1. Index and PC values are taken only in the start cycle.
- R12: `busy` is 1 from the cycle after start through the `done` cycle, `done` lasts one cycle, and with `start` low and `busy` low neither `mem_rd` nor `done` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an address computation (taken only when idle) |
| mode | input | 4 | Addressing-mode code |
| pc_in | input | 16 | Address of the first operand byte |
| x_in | input | 8 | X index register |
| y_in | input | 8 | Y index register |
| mem_rd | output | 1 | Byte read request |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the request |
| ea | output | 16 | Effective address or immediate value, valid with done |
| pc_out | output | 16 | Program counter past the operand, valid with done |
| done | output | 1 | Result valid (one cycle) |
| is_value | output | 1 | ea carries an operand value, not an address |
| err | output | 1 | Unknown mode code |
| busy | output | 1 | Computation in progress |

## Verification
Every one of the sixteen mode codes is run with several PC and index combinations. These include indices of 0xFF and 0xF0, which push page-zero sums and pointer fetches across the 0xFF-to-0x00 wrap, and a PC of 0xFFFF, which wraps the second operand read. The PCs chosen also yield both positive and negative branch offsets. Together these separate 8-bit wrapping from 16-bit wrapping and adding the index before the pointer fetch from adding it after. Further runs hold `start` high with different inputs while an operation is in flight, which shows whether the latched PC and indices are used and whether extra starts are ignored. Back-to-back operations check that the idle cycle between them stays quiet.

// File: rtl/eag_pkg.sv
package eag_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        MODE_NONE      = 4'd0,
        MODE_VALUE     = 4'd1,
        MODE_PAGE0     = 4'd2,
        MODE_PAGE0_X   = 4'd3,
        MODE_PAGE0_Y   = 4'd4,
        MODE_FULL      = 4'd5,
        MODE_FULL_X    = 4'd6,
        MODE_FULL_Y    = 4'd7,
        MODE_VIA_PTR   = 4'd8,
        MODE_PTR_PREX  = 4'd9,
        MODE_PTR_POSTY = 4'd10,
        MODE_BRANCH    = 4'd11,
        MODE_REG_A     = 4'd12
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPLO,
        ST_OPHI,
        ST_PTLO,
        ST_PTHI,
        ST_DONE
    } state_e;

    typedef enum logic [1:0] {
        IDX_NONE,
        IDX_X,
        IDX_Y
    } idx_e;

    typedef enum logic [1:0] {
        PTR_NONE,
        PTR_FAR,
        PTR_PAGE0
    } ptr_e;

    typedef struct packed {
        logic known;     // code is defined
        logic no_fetch;  // no operand bytes at all
        logic two_byte;  // 16-bit operand in the stream
        ptr_e ptr;       // pointer fetch kind
        idx_e pre_idx;   // index added before pointer fetch
        idx_e post_idx;  // index added to the final base
        logic branch;    // signed offset from next instruction
        logic value;     // operand byte is the result
    } plan_t;

    function automatic plan_t decode_mode(input logic [MODE_W-1:0] code);
        plan_t p;
        p = '{known: 1'b1, no_fetch: 1'b0, two_byte: 1'b0, ptr: PTR_NONE,
              pre_idx: IDX_NONE, post_idx: IDX_NONE, branch: 1'b0, value: 1'b0};
        case (code)
            MODE_NONE, MODE_REG_A: p.no_fetch = 1'b1;
            MODE_VALUE:     p.value = 1'b1;
            MODE_PAGE0:     ;
            MODE_PAGE0_X:   p.post_idx = IDX_X;
            MODE_PAGE0_Y:   p.post_idx = IDX_Y;
            MODE_FULL:      p.two_byte = 1'b1;
            MODE_FULL_X: begin
                p.two_byte = 1'b1;
                p.post_idx = IDX_X;
            end
            MODE_FULL_Y: begin
                p.two_byte = 1'b1;
                p.post_idx = IDX_Y;
            end
            MODE_VIA_PTR: begin
                p.two_byte = 1'b1;
                p.ptr      = PTR_FAR;
            end
            MODE_PTR_PREX: begin
                p.ptr     = PTR_PAGE0;
                p.pre_idx = IDX_X;
            end
            MODE_PTR_POSTY: begin
                p.ptr      = PTR_PAGE0;
                p.post_idx = IDX_Y;
            end
            MODE_BRANCH:    p.branch = 1'b1;
            default: begin
                p.known    = 1'b0;
                p.no_fetch = 1'b1;
            end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/eag_mode_dec.sv
module eag_mode_dec
    import eag_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output plan_t             plan
);
    always_comb plan = decode_mode(mode);
endmodule

// File: rtl/eag_ctrl.sv
module eag_ctrl
    import eag_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  plan_t  plan_now,
    input  plan_t  plan_q,
    output state_e state,
    output logic   launch,
    output logic   instant,
    output logic   done,
    output logic   err,
    output logic   busy
);
    state_e state_nx;
    logic   idle;

    always_comb begin
        idle    = (state == ST_IDLE);
        launch  = idle && start && plan_now.known && !plan_now.no_fetch;
        instant = idle && start && plan_now.no_fetch;
        err     = idle && start && !plan_now.known;
        done    = instant || (state == ST_DONE);
        busy    = !idle;
    end

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: if (launch) state_nx = ST_OPLO;
            ST_OPLO: begin
                if (plan_q.two_byte)              state_nx = ST_OPHI;
                else if (plan_q.ptr == PTR_PAGE0) state_nx = ST_PTLO;
                else                              state_nx = ST_DONE;
            end
            ST_OPHI: state_nx = (plan_q.ptr == PTR_FAR) ? ST_PTLO : ST_DONE;
            ST_PTLO: state_nx = ST_PTHI;
            ST_PTHI: state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end
endmodule

// File: rtl/eag_datapath.sv
module eag_datapath
    import eag_pkg::*;
#(
    parameter  int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  state_e        state,
    input  logic          launch,
    input  plan_t         plan_now,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] x_in,
    input  logic [DW-1:0] y_in,
    input  logic [DW-1:0] mem_rdata,
    output plan_t         plan_q,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] ea_q,
    output logic [AW-1:0] pcn_q,
    output logic          val_q
);
    logic [AW-1:0] pc_q;
    logic [DW-1:0] x_q, y_q;
    logic [DW-1:0] lo_q;
    logic [DW-1:0] plo_q;
    logic [AW-1:0] ptr_q;

    logic [DW-1:0] pre_v, post_v;
    logic [DW-1:0] zp_ptr;
    logic [AW-1:0] ptr_next;
    logic [AW-1:0] short_res;

    function automatic logic [DW-1:0] pick(input idx_e sel, input logic [DW-1:0] xv,
                                           input logic [DW-1:0] yv);
        case (sel)
            IDX_X:   return xv;
            IDX_Y:   return yv;
            default: return '0;
        endcase
    endfunction

    always_comb begin
        pre_v    = pick(plan_q.pre_idx, x_q, y_q);
        post_v   = pick(plan_q.post_idx, x_q, y_q);
        zp_ptr   = mem_rdata + pre_v;
        ptr_next = (plan_q.ptr == PTR_PAGE0) ? {{DW{1'b0}}, ptr_q[DW-1:0] + DW'(1)}
                                             : ptr_q + AW'(1);
        if (plan_q.branch)
            short_res = pc_q + AW'(1) + {{DW{mem_rdata[DW-1]}}, mem_rdata};
        else
            short_res = {{DW{1'b0}}, mem_rdata + post_v};
    end

    // read port: one request per cycle, data back on the next
    always_comb begin
        mem_rd   = 1'b0;
        mem_addr = '0;
        case (state)
            ST_IDLE: begin
                mem_rd   = launch;
                mem_addr = pc_in;
            end
            ST_OPLO: begin
                if (plan_q.two_byte) begin
                    mem_rd   = 1'b1;
                    mem_addr = pc_q + AW'(1);
                end else if (plan_q.ptr == PTR_PAGE0) begin
                    mem_rd   = 1'b1;
                    mem_addr = {{DW{1'b0}}, zp_ptr};
                end
            end
            ST_OPHI: begin
                if (plan_q.ptr == PTR_FAR) begin
                    mem_rd   = 1'b1;
                    mem_addr = {mem_rdata, lo_q};
                end
            end
            ST_PTLO: begin
                mem_rd   = 1'b1;
                mem_addr = ptr_next;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            plan_q <= '0;
            pc_q   <= '0;
            x_q    <= '0;
            y_q    <= '0;
            lo_q   <= '0;
            plo_q  <= '0;
            ptr_q  <= '0;
            ea_q   <= '0;
            pcn_q  <= '0;
            val_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (launch) begin
                        plan_q <= plan_now;
                        pc_q   <= pc_in;
                        x_q    <= x_in;
                        y_q    <= y_in;
                        pcn_q  <= pc_in + (plan_now.two_byte ? AW'(2) : AW'(1));
                        val_q  <= 1'b0;
                    end
                end
                ST_OPLO: begin
                    lo_q <= mem_rdata;
                    if (plan_q.ptr == PTR_PAGE0)
                        ptr_q <= {{DW{1'b0}}, zp_ptr};
                    if (!plan_q.two_byte && plan_q.ptr == PTR_NONE) begin
                        ea_q  <= short_res;
                        val_q <= plan_q.value;
                    end
                end
                ST_OPHI: begin
                    if (plan_q.ptr == PTR_FAR)
                        ptr_q <= {mem_rdata, lo_q};
                    else
                        ea_q <= {mem_rdata, lo_q} + {{DW{1'b0}}, post_v};
                end
                ST_PTLO: plo_q <= mem_rdata;
                ST_PTHI: ea_q  <= {mem_rdata, plo_q} + {{DW{1'b0}}, post_v};
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/effective_addr_gen.sv
module effective_addr_gen
    import eag_pkg::*;
#(
    parameter  int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic [AW-1:0]     pc_in,
    input  logic [DW-1:0]     x_in,
    input  logic [DW-1:0]     y_in,
    output logic              mem_rd,
    output logic [AW-1:0]     mem_addr,
    input  logic [DW-1:0]     mem_rdata,
    output logic [AW-1:0]     ea,
    output logic [AW-1:0]     pc_out,
    output logic              done,
    output logic              is_value,
    output logic              err,
    output logic              busy
);
    plan_t         plan_now, plan_q;
    state_e        state;
    logic          launch, instant;
    logic [AW-1:0] ea_q, pcn_q;
    logic          val_q;

    eag_mode_dec u_dec (
        .mode (mode),
        .plan (plan_now)
    );

    eag_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .plan_now (plan_now),
        .plan_q   (plan_q),
        .state    (state),
        .launch   (launch),
        .instant  (instant),
        .done     (done),
        .err      (err),
        .busy     (busy)
    );

    eag_datapath #(.DW(DW)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .launch    (launch),
        .plan_now  (plan_now),
        .pc_in     (pc_in),
        .x_in      (x_in),
        .y_in      (y_in),
        .mem_rdata (mem_rdata),
        .plan_q    (plan_q),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .ea_q      (ea_q),
        .pcn_q     (pcn_q),
        .val_q     (val_q)
    );

    // modes without operand bytes (and bad codes) answer in the start cycle
    always_comb begin
        ea       = instant ? '0 : ea_q;
        pc_out   = instant ? pc_in : pcn_q;
        is_value = instant ? 1'b0 : val_q;
    end
endmodule

// File: rtl/eag_chk.sv
module eag_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [3:0]  mode,
    input logic        mem_rd,
    input logic        done,
    input logic        is_value,
    input logic        err,
    input logic        busy
);
    // R3: a bad code never reads and always completes at once
    assert_err_no_read_R3: assert property (@(posedge clk) disable iff (rst)
        err |-> (done && !mem_rd && !busy));

    // R2: operand-free modes finish in the start cycle without a read
    assert_no_operand_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (mode == 4'd0 || mode == 4'd12)) |-> (done && !mem_rd && !err));

    // R12: the in-flight done is a single pulse and ends the busy period
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        (done && busy) |=> (!busy && !done));

    // R12: idle with no start means a quiet port
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |-> (!mem_rd && !done));

    // R4: a value result only comes from a fetched operand
    assert_value_fetched_R4: assert property (@(posedge clk) disable iff (rst)
        (done && is_value) |-> busy);

    // R11: busy rises only after an accepted start
    assert_busy_from_start_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));
endmodule

bind effective_addr_gen eag_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .mode     (mode),
    .mem_rd   (mem_rd),
    .done     (done),
    .is_value (is_value),
    .err      (err),
    .busy     (busy)
);

// File: tb/effective_addr_gen_tb_top.sv
`timescale 1ns/1ps
module effective_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [15:0] pc_in = '0;
    logic [7:0]  x_in = '0;
    logic [7:0]  y_in = '0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic [15:0] ea, pc_out;
    logic        done, is_value, err, busy;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    effective_addr_gen dut_i (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .pc_in(pc_in),
        .x_in(x_in), .y_in(y_in), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .ea(ea), .pc_out(pc_out), .done(done),
        .is_value(is_value), .err(err), .busy(busy)
    );

    function automatic logic [7:0] memf(input logic [15:0] a);
        logic [7:0] lo_m, hi_m;
        lo_m = a[7:0] * 8'd29;
        hi_m = a[15:8] * 8'd7;
        return lo_m ^ hi_m ^ 8'h5A;
    endfunction

    // memory with one cycle of read latency
    always @(posedge clk) if (mem_rd) mem_rdata <= memf(mem_addr);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] m);
        case (m)
            4'd0, 4'd12:       return "R2";
            4'd1:              return "R4";
            4'd2, 4'd3, 4'd4:  return "R5";
            4'd5, 4'd6, 4'd7:  return "R6";
            4'd8:              return "R7";
            4'd9:              return "R8";
            4'd10:             return "R9";
            4'd11:             return "R10";
            default:           return "R3";
        endcase
    endfunction

    task automatic run_op(input logic [3:0] m, input logic [15:0] pc,
                          input logic [7:0] x, input logic [7:0] y, input bit poke);
        logic [15:0] rda [0:3];
        int nrd, ndone;
        logic [15:0] e_ea, e_pc, p;
        logic [7:0] b0, b1, z;
        bit e_val, e_err;
        string rq;
        rq = poke ? "R11" : req_of(m);
        b0 = memf(pc);
        b1 = memf(pc + 16'd1);
        nrd = 0; e_val = 1'b0; e_err = 1'b0; e_ea = '0; e_pc = pc + 16'd1;
        for (int i = 0; i < 4; i++) rda[i] = '0;
        case (m)
            4'd0, 4'd12: e_pc = pc;
            4'd1: begin nrd = 1; rda[0] = pc; e_ea = {8'h00, b0}; e_val = 1'b1; end
            4'd2: begin nrd = 1; rda[0] = pc; e_ea = {8'h00, b0}; end
            4'd3: begin nrd = 1; rda[0] = pc; z = b0 + x; e_ea = {8'h00, z}; end
            4'd4: begin nrd = 1; rda[0] = pc; z = b0 + y; e_ea = {8'h00, z}; end
            4'd5, 4'd6, 4'd7: begin
                nrd = 2; rda[0] = pc; rda[1] = pc + 16'd1; e_pc = pc + 16'd2;
                e_ea = {b1, b0} + ((m == 4'd6) ? {8'h00, x} : (m == 4'd7) ? {8'h00, y} : 16'h0);
            end
            4'd8: begin
                p = {b1, b0};
                nrd = 4; rda[0] = pc; rda[1] = pc + 16'd1; rda[2] = p; rda[3] = p + 16'd1;
                e_ea = {memf(p + 16'd1), memf(p)}; e_pc = pc + 16'd2;
            end
            4'd9: begin
                z = b0 + x;
                nrd = 3; rda[0] = pc; rda[1] = {8'h00, z}; rda[2] = {8'h00, 8'(z + 8'd1)};
                e_ea = {memf({8'h00, 8'(z + 8'd1)}), memf({8'h00, z})};
            end
            4'd10: begin
                nrd = 3; rda[0] = pc; rda[1] = {8'h00, b0}; rda[2] = {8'h00, 8'(b0 + 8'd1)};
                e_ea = {memf({8'h00, 8'(b0 + 8'd1)}), memf({8'h00, b0})} + {8'h00, y};
            end
            4'd11: begin
                nrd = 1; rda[0] = pc; e_ea = pc + 16'd1 + {{8{b0[7]}}, b0};
            end
            default: begin e_err = 1'b1; e_pc = pc; end
        endcase
        ndone = (nrd == 0) ? 0 : nrd + 1;

        @(negedge clk);
        start = 1'b1; mode = m; pc_in = pc; x_in = x; y_in = y;
        for (int c = 0; c <= ndone; c++) begin
            if (c > 0) begin
                @(negedge clk);
                if (poke) begin
                    start = 1'b1; mode = 4'd8; pc_in = ~pc; x_in = ~x; y_in = ~y;
                end else begin
                    start = 1'b0;
                end
            end
            #1;
            chk(mem_rd == (c < nrd), rq, $sformatf("mem_rd cyc%0d", c), 32'(mem_rd), 32'(c < nrd));
            if (c < nrd)
                chk(mem_addr == rda[c], rq, $sformatf("mem_addr cyc%0d", c), 32'(mem_addr), 32'(rda[c]));
            chk(done == (c == ndone), rq, $sformatf("done cyc%0d", c), 32'(done), 32'(c == ndone));
            chk(busy == (c > 0), "R12", $sformatf("busy cyc%0d", c), 32'(busy), 32'(c > 0));
            chk(err == (e_err && c == ndone), rq, "err", 32'(err), 32'(e_err && c == ndone));
            if (c == ndone) begin
                chk(ea == e_ea, rq, "ea", 32'(ea), 32'(e_ea));
                chk(pc_out == e_pc, rq, "pc_out", 32'(pc_out), 32'(e_pc));
                chk(is_value == e_val, "R4", "is_value", 32'(is_value), 32'(e_val));
            end
        end
        @(negedge clk);
        start = 1'b0;
        #1;
        chk(!done && !mem_rd && !busy, "R12", "quiet after done",
            {29'd0, done, mem_rd, busy}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!done && !err && !busy && !mem_rd, "R1", "outputs in reset",
            {28'd0, done, err, busy, mem_rd}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!done && !err && !busy && !mem_rd, "R1", "outputs after reset",
            {28'd0, done, err, busy, mem_rd}, 32'd0);

        for (int k = 0; k < 6; k++) begin
            for (int m = 0; m < 16; m++) begin
                logic [15:0] pc;
                logic [7:0] xv, yv;
                pc = (k == 5) ? 16'hFFFF : 16'(16'h0600 + k * 16'h3B1 + m * 16'h17);
                xv = (k == 1) ? 8'hFF : (k == 2) ? 8'hF0 : 8'(k * 8'h35 + 8'h03);
                yv = (k == 3) ? 8'hFF : (k == 4) ? 8'h00 : 8'(k * 8'h4B + 8'h81);
                run_op(4'(m), pc, xv, yv, 1'b0);
            end
        end
        // R10: sweep relative offsets over many start addresses
        for (int k = 0; k < 24; k++) run_op(4'd11, 16'(16'h0100 + k * 16'h0B), 8'h00, 8'h00, 1'b0);
        // R11: extra starts with other inputs while in flight
        run_op(4'd8, 16'h2345, 8'h11, 8'h22, 1'b1);
        run_op(4'd9, 16'h0402, 8'hFE, 8'h33, 1'b1);
        run_op(4'd10, 16'h7777, 8'h44, 8'hF1, 1'b1);
        run_op(4'd6, 16'h1000, 8'hC8, 8'h00, 1'b1);
        run_op(4'd3, 16'h0080, 8'hA0, 8'h00, 1'b1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(10 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R12 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule